// File: doc/BRIEF.md
# Integer Multiply/Divide Unit

This block carries out the eight 32-bit multiply, divide and remainder operations of the standard integer multiply/divide extension. It receives requests that the instruction decoder has already marked as belonging to that group: the major opcode is 0110011 and the upper function field is 0000001. Each request carries a 3-bit operation code, two source operands and a destination tag. The block returns a 32-bit result together with the same tag.

Both sides use a valid/ready handshake. The unit works on one request at a time. Once a request is accepted, `in_ready` stays low until the result has been taken through `out_ready`.

Multiplies use a single combinational 64-bit product and return one clock edge after acceptance. Divides and remainders use a radix-2 restoring divider that works on operand magnitudes. The divider has one load edge, one edge per quotient bit and one sign-fixup edge.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A request is accepted on a rising edge when `in_valid` and `in_ready` are both 1. From the next cycle `in_ready` stays 0 until the result is consumed. Requests presented while `in_ready` is 0 are ignored.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_result` and `out_tag` hold their values.
- R4: `out_tag` equals the `in_tag` of the accepted request whose result is being returned.
- R5: Operation code 000 returns the low 32 bits of the product. For codes 000 to 011, `out_valid` rises one edge after the accepting edge.
- R6: Code 001 returns product bits 63..32, with both operands signed.
- R7: Code 010 returns product bits 63..32, with `in_a` signed and `in_b` unsigned.
- R8: Code 011 returns product bits 63..32, with both operands unsigned.
- R9: Code 100 returns the signed quotient and code 110 the signed remainder. The quotient truncates toward zero and the remainder has the sign of the dividend.
- R10: Code 101 returns the unsigned quotient and code 111 the unsigned remainder.
- R11: With a zero divisor, the quotient codes (100, 101) return all ones and the remainder codes (110, 111) return `in_a` unchanged.
- R12: For the signed case of 0x80000000 divided by 0xFFFFFFFF, code 100 returns 0x80000000 and code 110 returns 0.
- R13: For codes 100 to 111, `out_valid` rises 33 edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_op | input | 3 | Operation code (function field 3) |
| in_a | input | XLEN | First source operand / dividend |
| in_b | input | XLEN | Second source operand / divisor |
| in_tag | input | TAG_W | Destination tag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | XLEN | Result word |
| out_tag | output | TAG_W | Tag of the returned result |

## Verification
The bench targets the operand patterns where the sign treatment decides the answer. These are all-ones and minimum-value operands for the three high-product codes. A unit that extended the wrong operand's sign would return a high word that differs by a multiple of the other operand.

Signed division is run with each sign combination. A divider that floored instead of truncating, or that gave the remainder the divisor's sign, shows up there.

Zero divisors are tried with a negative dividend. A design that only let the magnitude divider run would return the magnitude, or a sign-flipped quotient, instead of all ones and the original dividend. The most-negative value divided by minus one is also checked, since it overflows the magnitude path.

Back-pressure is exercised by holding the result unconsumed while a competing request waits. A unit that dropped its result or took the second request would change `out_result` or bring `out_valid` back too early.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [2:0] {
    OP_MUL    = 3'b000,
    OP_MULH   = 3'b001,
    OP_MULHSU = 3'b010,
    OP_MULHU  = 3'b011,
    OP_DIV    = 3'b100,
    OP_DIVU   = 3'b101,
    OP_REM    = 3'b110,
    OP_REMU   = 3'b111
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_DIV,
    ST_HOLD
  } md_state_e;

  typedef enum logic [1:0] {
    DV_IDLE,
    DV_ITER,
    DV_FIX
  } dv_phase_e;

endpackage

// File: rtl/md_mul.sv
module md_mul import muldiv_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  localparam int PW = 2 * XLEN;

  logic          a_sx;
  logic          b_sx;
  logic [PW-1:0] wa;
  logic [PW-1:0] wb;
  logic [PW-1:0] prod;

  // The first operand is signed for the signed-high and mixed-high forms;
  // the second one only for the signed-high form.
  always_comb begin
    a_sx = a[XLEN-1] & ((op == OP_MULH) || (op == OP_MULHSU));
    b_sx = b[XLEN-1] & (op == OP_MULH);
    wa   = {{XLEN{a_sx}}, a};
    wb   = {{XLEN{b_sx}}, b};
    // Low PW bits of the product of the extended words are exact.
    prod = wa * wb;
    res  = (op == OP_MUL) ? prod[XLEN-1:0] : prod[PW-1:XLEN];
  end

endmodule

// File: rtl/md_div.sv
module md_div import muldiv_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            is_signed,
  input  logic            want_rem,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            done,
  output logic [XLEN-1:0] res
);
  localparam int CW = $clog2(XLEN);
  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

  dv_phase_e       phase;
  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] rem_q;
  logic [XLEN-1:0] quo_q;
  logic [XLEN-1:0] dsr_q;
  logic [XLEN-1:0] dvd_q;
  logic            neg_q_q;
  logic            neg_r_q;
  logic            zero_q;
  logic            rem_sel_q;

  logic            neg_a;
  logic            neg_b;
  logic [XLEN:0]   shifted;
  logic [XLEN:0]   diff;
  logic            fits;
  logic [XLEN-1:0] q_fin;
  logic [XLEN-1:0] r_fin;

  assign neg_a   = is_signed & a[XLEN-1];
  assign neg_b   = is_signed & b[XLEN-1];

  // One restoring step: bring in the next dividend bit, try the subtract.
  assign shifted = {rem_q, quo_q[XLEN-1]};
  assign diff    = shifted - {1'b0, dsr_q};
  assign fits    = ~diff[XLEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= DV_IDLE;
      cnt       <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      dsr_q     <= '0;
      dvd_q     <= '0;
      neg_q_q   <= 1'b0;
      neg_r_q   <= 1'b0;
      zero_q    <= 1'b0;
      rem_sel_q <= 1'b0;
    end else begin
      case (phase)
        DV_IDLE: begin
          if (start) begin
            phase     <= DV_ITER;
            cnt       <= '0;
            rem_q     <= '0;
            quo_q     <= neg_a ? -a : a;
            dsr_q     <= neg_b ? -b : b;
            dvd_q     <= a;
            neg_q_q   <= neg_a ^ neg_b;
            neg_r_q   <= neg_a;
            zero_q    <= (b == '0);
            rem_sel_q <= want_rem;
          end
        end
        DV_ITER: begin
          rem_q <= fits ? diff[XLEN-1:0] : shifted[XLEN-1:0];
          quo_q <= {quo_q[XLEN-2:0], fits};
          cnt   <= cnt + CW'(1);
          if (cnt == LAST) begin
            phase <= DV_FIX;
          end
        end
        DV_FIX: begin
          phase <= DV_IDLE;
        end
        default: phase <= DV_IDLE;
      endcase
    end
  end

  // Sign fixup and the zero-divisor substitution.
  always_comb begin
    q_fin = neg_q_q ? -quo_q : quo_q;
    r_fin = neg_r_q ? -rem_q : rem_q;
    if (zero_q) begin
      res = rem_sel_q ? dvd_q : '1;
    end else begin
      res = rem_sel_q ? r_fin : q_fin;
    end
  end

  assign done = (phase == DV_FIX);

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit import muldiv_pkg::*; #(
  parameter int XLEN  = 32,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [XLEN-1:0]  in_a,
  input  logic [XLEN-1:0]  in_b,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_result,
  output logic [TAG_W-1:0] out_tag
);

  md_state_e        state;
  logic [2:0]       op_q;
  logic [XLEN-1:0]  a_q;
  logic [XLEN-1:0]  b_q;
  logic [TAG_W-1:0] tag_q;
  logic [XLEN-1:0]  res_q;
  logic             accept;
  logic             div_start;
  logic             div_done;
  logic [XLEN-1:0]  div_res;
  logic [XLEN-1:0]  mul_res;

  assign in_ready  = (state == ST_IDLE);
  assign accept    = in_valid & in_ready;
  assign div_start = accept & in_op[2];

  md_mul #(.XLEN(XLEN)) i_mul (
    .op  (op_q),
    .a   (a_q),
    .b   (b_q),
    .res (mul_res)
  );

  md_div #(.XLEN(XLEN)) i_div (
    .clk       (clk),
    .rst       (rst),
    .start     (div_start),
    .is_signed (~in_op[0]),
    .want_rem  (in_op[1]),
    .a         (in_a),
    .b         (in_b),
    .done      (div_done),
    .res       (div_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      op_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      tag_q <= '0;
      res_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_q  <= in_op;
            a_q   <= in_a;
            b_q   <= in_b;
            tag_q <= in_tag;
            state <= in_op[2] ? ST_DIV : ST_MUL;
          end
        end
        ST_MUL: begin
          res_q <= mul_res;
          state <= ST_HOLD;
        end
        ST_DIV: begin
          if (div_done) begin
            res_q <= div_res;
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (out_ready) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_valid  = (state == ST_HOLD);
  assign out_result = res_q;
  assign out_tag    = tag_q;

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int XLEN  = 32,
  parameter int TAG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic             out_valid,
  input logic             out_ready,
  input logic [XLEN-1:0]  out_result,
  input logic [TAG_W-1:0] in_tag,
  input logic [TAG_W-1:0] out_tag
);
  logic [TAG_W-1:0] exp_tag;
  logic             trk_div;
  logic [15:0]      wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_tag <= '0;
      trk_div <= 1'b0;
      wcnt    <= '0;
    end else if (in_valid && in_ready) begin
      exp_tag <= in_tag;
      trk_div <= in_op[2];
      wcnt    <= '0;
    end else if (!out_valid) begin
      wcnt <= wcnt + 16'd1;
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  p_no_take_while_valid_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_tag)));

  p_tag_match_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_tag == exp_tag));

  p_mul_latency_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_op[2]) |=> ##1 out_valid);

  p_div_latency_r13: assert property (@(posedge clk) disable iff (rst)
    ($rose(out_valid) && trk_div) |-> (wcnt == 16'(XLEN + 1)));

endmodule

bind muldiv_unit muldiv_unit_chk #(.XLEN(XLEN), .TAG_W(TAG_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .in_tag     (in_tag),
  .out_tag    (out_tag)
);

// File: tb/test_muldiv_unit.sv
`timescale 1ns/1ps
module test_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [2:0]  in_op;
  logic [31:0] in_a;
  logic [31:0] in_b;
  logic [4:0]  in_tag;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_result;
  logic [4:0]  out_tag;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  muldiv_unit #(.XLEN(32), .TAG_W(5)) i_muldiv_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_tag(out_tag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_md(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa;
    logic signed [63:0] sb;
    logic [63:0] ua;
    logic [63:0] ub;
    logic [63:0] p;
    logic ovf;
    sa  = {{32{a[31]}}, a};
    sb  = {{32{b[31]}}, b};
    ua  = {32'b0, a};
    ub  = {32'b0, b};
    ovf = (a == 32'h8000_0000) && (b == 32'hFFFF_FFFF);
    p   = '0;
    case (op)
      3'd0: begin p = ua * ub; return p[31:0]; end
      3'd1: begin p = sa * sb; return p[63:32]; end
      3'd2: begin p = sa * $signed(ub); return p[63:32]; end
      3'd3: begin p = ua * ub; return p[63:32]; end
      3'd4: begin
        if (b == 0) return 32'hFFFF_FFFF;
        if (ovf) return 32'h8000_0000;
        return $signed(a) / $signed(b);
      end
      3'd5: return (b == 0) ? 32'hFFFF_FFFF : a / b;
      3'd6: begin
        if (b == 0) return a;
        if (ovf) return 32'h0;
        return $signed(a) % $signed(b);
      end
      default: return (b == 0) ? a : a % b;
    endcase
  endfunction

  // Issue one request, wait for its result, consume it. lat counts the
  // edges after the accepting edge up to the one that raised out_valid.
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] tag, output logic [31:0] res, output int lat);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_tag = tag; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    res = out_result;
    check("R4 tag", {27'b0, out_tag}, {27'b0, tag});
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0; in_tag = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    check("R1 in_ready", {31'b0, in_ready}, 32'd1);
  endtask

  task automatic t_mul_op(input logic [2:0] op, input string req);
    logic [31:0] av [5];
    logic [31:0] bv [5];
    logic [31:0] r;
    int lat;
    av[0] = 32'd7;          bv[0] = 32'd6;
    av[1] = 32'hFFFF_FFFF;  bv[1] = 32'hFFFF_FFFF;
    av[2] = 32'h8000_0000;  bv[2] = 32'd2;
    av[3] = 32'h1234_5678;  bv[3] = 32'h9ABC_DEF0;
    av[4] = 32'h8000_0000;  bv[4] = 32'h8000_0000;
    for (int i = 0; i < 5; i++) begin
      run_op(op, av[i], bv[i], 5'(i + op * 5), r, lat);
      check(req, r, ref_md(op, av[i], bv[i]));
      check("R5 mul latency", lat, 32'd1);
    end
  endtask

  task automatic t_signed_div();
    logic [31:0] av [5];
    logic [31:0] bv [5];
    logic [31:0] r;
    int lat;
    av[0] = 32'd7;   bv[0] = 32'd2;
    av[1] = -32'd7;  bv[1] = 32'd2;
    av[2] = 32'd7;   bv[2] = -32'd2;
    av[3] = -32'd7;  bv[3] = -32'd2;
    av[4] = 32'h8000_0000; bv[4] = 32'd3;
    for (int i = 0; i < 5; i++) begin
      run_op(3'd4, av[i], bv[i], 5'(i), r, lat);
      check("R9 signed quotient", r, ref_md(3'd4, av[i], bv[i]));
      run_op(3'd6, av[i], bv[i], 5'(i + 8), r, lat);
      check("R9 signed remainder", r, ref_md(3'd6, av[i], bv[i]));
    end
    run_op(3'd6, -32'd7, 32'd2, 5'd3, r, lat);
    check("R9 remainder sign of dividend", r, 32'hFFFF_FFFF);
  endtask

  task automatic t_unsigned_div();
    logic [31:0] av [4];
    logic [31:0] bv [4];
    logic [31:0] r;
    int lat;
    av[0] = 32'hFFFF_FFFF; bv[0] = 32'd3;
    av[1] = 32'd100;       bv[1] = 32'd7;
    av[2] = 32'd5;         bv[2] = 32'd9;
    av[3] = 32'h8000_0000; bv[3] = 32'hFFFF_FFFF;
    for (int i = 0; i < 4; i++) begin
      run_op(3'd5, av[i], bv[i], 5'(i + 16), r, lat);
      check("R10 unsigned quotient", r, ref_md(3'd5, av[i], bv[i]));
      check("R13 divide latency", lat, 32'd33);
      run_op(3'd7, av[i], bv[i], 5'(i + 20), r, lat);
      check("R10 unsigned remainder", r, ref_md(3'd7, av[i], bv[i]));
    end
  endtask

  task automatic t_div_zero();
    logic [31:0] r;
    int lat;
    logic [31:0] dv [2];
    dv[0] = 32'h8000_0001;
    dv[1] = 32'd5;
    for (int i = 0; i < 2; i++) begin
      run_op(3'd4, dv[i], 32'd0, 5'd1, r, lat);
      check("R11 div by zero quotient", r, 32'hFFFF_FFFF);
      run_op(3'd5, dv[i], 32'd0, 5'd2, r, lat);
      check("R11 divu by zero quotient", r, 32'hFFFF_FFFF);
      run_op(3'd6, dv[i], 32'd0, 5'd3, r, lat);
      check("R11 rem by zero", r, dv[i]);
      run_op(3'd7, dv[i], 32'd0, 5'd4, r, lat);
      check("R11 remu by zero", r, dv[i]);
    end
  endtask

  task automatic t_overflow();
    logic [31:0] r;
    int lat;
    run_op(3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 5'd9, r, lat);
    check("R12 overflow quotient", r, 32'h8000_0000);
    run_op(3'd6, 32'h8000_0000, 32'hFFFF_FFFF, 5'd10, r, lat);
    check("R12 overflow remainder", r, 32'h0);
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    int n;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 3'd5; in_a = 32'd100; in_b = 32'd7; in_tag = 5'd27;
    @(negedge clk);
    check("R2 ready low after accept", {31'b0, in_ready}, 32'd0);
    // Competing multiply request stays presented throughout.
    in_op = 3'd0; in_a = 32'd3; in_b = 32'd3; in_tag = 5'd1;
    n = 0;
    while (!out_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    held = out_result;
    check("R10 result under backpressure", held, 32'd14);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R3 valid held", {31'b0, out_valid}, 32'd1);
      check("R3 result held", out_result, held);
      check("R3 tag held", {27'b0, out_tag}, 32'd27);
      check("R2 ready low while result pending", {31'b0, in_ready}, 32'd0);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R2 consumed", {31'b0, out_valid}, 32'd0);
    check("R2 ready back", {31'b0, in_ready}, 32'd1);
    @(negedge clk);
    @(negedge clk);
    check("R2 ignored request not executed", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_mul_op(3'd0, "R5 MUL low word");
    t_mul_op(3'd1, "R6 MULH signed high");
    t_mul_op(3'd2, "R7 MULHSU mixed high");
    t_mul_op(3'd3, "R8 MULHU unsigned high");
    t_signed_div();
    t_unsigned_div();
    t_div_zero();
    t_overflow();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule